// File: doc/BRIEF.md
# Dual-Rate Overcurrent Trip Filter

This block decides whether an overcurrent reported by an external comparator is real, and turns off the pass-transistor gate drive when it is. It samples the single-bit overcurrent flag on a sample tick. The tick period depends on the power state. While the supply is ramping, the block samples on a short interval so that a shorted card is caught quickly. Once the transistors are fully on, it samples on a long interval, which makes it more tolerant of brief current spikes.

A run of consecutive positive samples trips the breaker. The gate enable drops at the same clock edge that records the final positive sample. The trip is held until a clear pulse or a reset. The gate enable is the external enable qualified by "not tripped". The reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `ocp_trip_filter`

## Requirements
- R1: While reset is held, `tripped` is 0 and `gate_en` equals `ext_en`.
- R2: With `ramp_mode`=1, the flag is sampled once every FAST_CYC clock cycles. The first sample falls FAST_CYC+2 edges after `rst_n` rises.
- R3: With `ramp_mode`=0, the flag is sampled once every SLOW_CYC clock cycles. The first sample falls SLOW_CYC+2 edges after `rst_n` rises.
- R4: The TRIP_RUN-th consecutive sample with `oc_flag`=1 sets `tripped` to 1 and clears `gate_en` at the edge that takes that sample.
- R5: A sample with `oc_flag`=0 zeroes the consecutive count. A later trip then needs a full TRIP_RUN new positive samples.
- R6: Once tripped, the block stays tripped whatever `oc_flag` does, until `clear` or reset.
- R7: `clear` high at an edge leaves `tripped` at 0 and the count at zero after that edge. It does not move the sample schedule.
- R8: A change of `ramp_mode` restarts the interval at the edge where the change is seen. The next sample comes a full new interval later. The consecutive count is kept.
- R9: `gate_en` is 1 only when `ext_en` is 1 and the block is not tripped. `ext_en` has no effect on sampling or tripping.
- R10: After `rst_n` rises, internal state leaves reset at the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_flag | input | 1 | Overcurrent flag from the external comparator, 1 = overcurrent |
| ramp_mode | input | 1 | 1 = supply ramping (fast interval), 0 = normal (slow interval) |
| ext_en | input | 1 | External gate-drive request |
| clear | input | 1 | Clears a trip and the consecutive count |
| gate_en | output | 1 | Pass-transistor gate enable |
| tripped | output | 1 | Breaker tripped status |

## Verification
The bench sweeps the position of a single negative sample through every point of a run, in both modes, and predicts the trip edge arithmetically. A filter that fails to zero its count on a negative sample would trip early, and an off-by-one run length would trip one tick early or late. A clear in the middle of a run must force a full new run on an unchanged tick schedule. Mode switches in both directions, part way through an interval, must restart the interval but keep the count. A design that kept the old phase, or dropped the count, would trip at a different edge. Constant overcurrent in each mode, trip latching under a quiet flag, and the effect of the external enable on the gate are checked at exact edges.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_RAMP   = 1'b1
  } pwr_mode_e;
endpackage

// File: rtl/ocp_rst_sync.sv
module ocp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_q_n = s2_q;
endmodule

// File: rtl/ocp_tick_gen.sv
module ocp_tick_gen
  import ocp_pkg::*;
#(
  parameter int FAST_CYC = 25,
  parameter int SLOW_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ramp_mode,
  output logic tick
);
  localparam int MAXC = (FAST_CYC > SLOW_CYC) ? FAST_CYC : SLOW_CYC;
  localparam int CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] FAST_M1 = CW'(FAST_CYC - 1);
  localparam logic [CW-1:0] SLOW_M1 = CW'(SLOW_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d, limit_m1;
  pwr_mode_e     mode_cur, mode_q;
  logic          mode_chg;

  always_comb begin
    mode_cur = pwr_mode_e'(ramp_mode);
    limit_m1 = (mode_cur == MODE_RAMP) ? FAST_M1 : SLOW_M1;
    mode_chg = (mode_cur != mode_q);
    tick     = !mode_chg && (cnt_q == limit_m1);
    if (mode_chg || tick) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  // mode tracker runs through reset so a static mode is not seen as a change
  always_ff @(posedge clk) begin
    mode_q <= mode_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: a restart is never followed directly by a sample
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !tick);
  // R2/R3: the interval counter stays within the selected interval
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_chg |-> (cnt_q <= limit_m1));
endmodule

// File: rtl/ocp_run_latch.sv
module ocp_run_latch #(
  parameter int TRIP_RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic oc_flag,
  input  logic clear,
  output logic trip
);
  localparam int RUN_W = $clog2(TRIP_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(TRIP_RUN - 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(TRIP_RUN);

  logic [RUN_W-1:0] run_q, run_d;
  logic             trip_q, trip_d, upd_en;

  always_comb begin
    run_d  = run_q;
    trip_d = trip_q;
    upd_en = clear || (tick && !trip_q);
    if (clear) begin
      run_d  = '0;
      trip_d = 1'b0;
    end else if (tick && !trip_q) begin
      if (oc_flag) begin
        if (run_q == RUN_LAST) begin
          run_d  = RUN_FULL;
          trip_d = 1'b1;
        end else begin
          run_d = run_q + 1'b1;
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      trip_q <= 1'b0;
    end else if (upd_en) begin
      run_q  <= run_d;
      trip_q <= trip_d;
    end
  end

  assign trip = trip_q;

  assert_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_FULL);
  assert_trip_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> $past(tick && oc_flag && (run_q == RUN_LAST)));
  assert_gap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !oc_flag && !clear && !trip_q) |=> (run_q == '0));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !clear) |=> trip_q);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!trip_q && (run_q == '0)));
endmodule

// File: rtl/ocp_trip_filter.sv
module ocp_trip_filter #(
  parameter int FAST_CYC = 25,
  parameter int SLOW_CYC = 100,
  parameter int TRIP_RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_flag,
  input  logic ramp_mode,
  input  logic ext_en,
  input  logic clear,
  output logic gate_en,
  output logic tripped
);
  logic rst_q_n, tick, trip;

  ocp_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ocp_tick_gen #(
    .FAST_CYC (FAST_CYC),
    .SLOW_CYC (SLOW_CYC)
  ) u_tick (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .ramp_mode (ramp_mode),
    .tick      (tick)
  );

  ocp_run_latch #(
    .TRIP_RUN (TRIP_RUN)
  ) u_run (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .tick    (tick),
    .oc_flag (oc_flag),
    .clear   (clear),
    .trip    (trip)
  );

  assign gate_en = ext_en && !trip;
  assign tripped = trip;

  // R9: a disabled external request never leaves the gate on
  assert_gate_off_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ext_en |-> !gate_en);
endmodule

// File: tb/test_ocp_trip_filter.sv
module test_ocp_trip_filter;
  localparam int LF = 3;
  localparam int LS = 5;
  localparam int TR = 4;

  logic clk = 1'b0;
  logic rst_n, oc_flag, ramp_mode, ext_en, clear;
  logic gate_en, tripped;
  int   checks = 0;
  int   fails  = 0;
  int   edge_no = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  ocp_trip_filter #(.FAST_CYC(LF), .SLOW_CYC(LS), .TRIP_RUN(TR)) i_ocp_trip_filter (
    .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .ramp_mode(ramp_mode),
    .ext_en(ext_en), .clear(clear), .gate_en(gate_en), .tripped(tripped)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b edge=%0d", tag, act, exp, edge_no);
    end
  endtask

  task automatic go_to(input int e);
    while (edge_no < e) begin
      @(posedge clk);
      edge_no++;
    end
    #1;
  endtask

  task automatic do_reset(input logic mode, input logic oc);
    @(posedge clk); #1;
    rst_n = 1'b0; ramp_mode = mode; oc_flag = oc; clear = 1'b0; ext_en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    edge_no = 0;
  endtask

  initial begin
    rst_n = 1'b0; oc_flag = 1'b0; ramp_mode = 1'b1; ext_en = 1'b1; clear = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(tripped, 1'b0, "R1 tripped in reset");
    check(gate_en, 1'b1, "R1 gate_en follows ext_en=1 in reset");
    oc_flag = 1'b1;
    repeat (20) @(posedge clk);
    #1;
    check(tripped, 1'b0, "R1 no trip while reset held");
    ext_en = 1'b0; #1;
    check(gate_en, 1'b0, "R1 gate_en follows ext_en=0 in reset");

    // R2/R3/R4/R10: constant overcurrent trips at edge 2+TR*L; R6/R7 latch and clear
    for (int m = 0; m < 2; m++) begin
      automatic int L = (m == 1) ? LF : LS;
      automatic string rq = (m == 1) ? "R2" : "R3";
      do_reset(logic'(m), 1'b1);
      go_to(1 + TR * L);
      check(tripped, 1'b0, {rq, " R10 no trip one edge early"});
      check(gate_en, 1'b1, {rq, " gate on before trip"});
      go_to(2 + TR * L);
      check(tripped, 1'b1, {rq, " R4 trip on last sample"});
      check(gate_en, 1'b0, "R4 gate off at trip edge");
      oc_flag = 1'b0;
      go_to(2 + (TR + 3) * L);
      check(tripped, 1'b1, "R6 trip held with quiet flag");
      clear = 1'b1;
      go_to(3 + (TR + 3) * L);
      clear = 1'b0;
      check(tripped, 1'b0, "R7 clear releases trip");
      check(gate_en, 1'b1, "R7 gate back on after clear");
    end

    // R5: one negative sample after k positives, sweep k in both modes
    for (int m = 0; m < 2; m++) begin
      for (int k = 1; k < TR; k++) begin
        automatic int L = (m == 1) ? LF : LS;
        do_reset(logic'(m), 1'b1);
        go_to(2 + k * L);
        check(tripped, 1'b0, "R5 no trip before gap");
        oc_flag = 1'b0;
        go_to(2 + (k + 1) * L);
        oc_flag = 1'b1;
        go_to(1 + (k + 1 + TR) * L);
        check(tripped, 1'b0, "R5 count zeroed by negative sample");
        go_to(2 + (k + 1 + TR) * L);
        check(tripped, 1'b1, "R5 trip after full new run");
      end
    end

    // R7: clear in the middle of a run, schedule unchanged
    do_reset(1'b1, 1'b1);
    go_to(2 + (TR - 1) * LF);
    clear = 1'b1;
    go_to(3 + (TR - 1) * LF);
    clear = 1'b0;
    check(tripped, 1'b0, "R7 no trip after mid-run clear");
    go_to(1 + (2 * TR - 1) * LF);
    check(tripped, 1'b0, "R7 clear zeroed count");
    go_to(2 + (2 * TR - 1) * LF);
    check(tripped, 1'b1, "R7 trip on unchanged schedule");

    // R8: ramp -> normal after 2 samples, switch seen at edge 9
    do_reset(1'b1, 1'b1);
    go_to(2 + 2 * LF);
    ramp_mode = 1'b0;
    go_to(9 + (TR - 2) * LS - 1);
    check(tripped, 1'b0, "R8 ramp->normal no early trip");
    go_to(9 + (TR - 2) * LS);
    check(tripped, 1'b1, "R8 ramp->normal count kept, interval restarted");

    // R8: normal -> ramp after 1 sample, switch seen at edge 9
    do_reset(1'b0, 1'b1);
    go_to(8);
    ramp_mode = 1'b1;
    go_to(9 + (TR - 1) * LF - 1);
    check(tripped, 1'b0, "R8 normal->ramp no early trip");
    go_to(9 + (TR - 1) * LF);
    check(tripped, 1'b1, "R8 normal->ramp count kept, interval restarted");

    // R9: external enable gates output but not tripping
    do_reset(1'b1, 1'b0);
    go_to(4);
    ext_en = 1'b0; #1;
    check(gate_en, 1'b0, "R9 gate off with ext_en=0");
    check(tripped, 1'b0, "R9 not tripped");
    ext_en = 1'b1; #1;
    check(gate_en, 1'b1, "R9 gate on with ext_en=1");
    ext_en = 1'b0;
    go_to(2 + LF);
    oc_flag = 1'b1;
    go_to(1 + (TR + 1) * LF);
    check(tripped, 1'b0, "R9 no trip one edge early with ext_en=0");
    go_to(2 + (TR + 1) * LF);
    check(tripped, 1'b1, "R9 trip independent of ext_en");
    ext_en = 1'b1; #1;
    check(gate_en, 1'b0, "R9 gate stays off while tripped");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule